// File: doc/BRIEF.md
# DMA-Input Byte Loader

The loader writes a block of bytes into a processor's memory by way of the processor's DMA-input request line. It produces no addresses. The processor stores each byte at the address held in its register 0 and then increments that register. The loader only has to present the byte and run the request handshake. A host starts a transfer with a length. Bytes then arrive one at a time on a valid/ready stream.

For each byte, the loader first latches the byte and drives it on its data output. It waits a settling time, then raises the request. The processor signals that it is servicing the request through its 2-bit state code: value binary 10 means the processor is in its DMA state. When the loader sees that code, it drops the request. It then waits for the code to leave the DMA state before it accepts the next byte. The output enable of the data bus follows the DMA state code, so the loader only drives the shared bus while the processor samples it.

A timeout guards the two waits on the processor. If either wait expires, the loader raises a sticky error flag, releases the bus and returns to idle without signalling completion.

Top module: `dma_in_loader`

## Requirements
- R1: After a start with a nonzero length, `byte_ready_o` is high in the next cycle and stays high until a byte is accepted. The accepted byte is then held on `data_o`.
- R2: `dma_req_o` rises exactly SETTLE_CYCLES clock cycles after the edge that accepts a byte. `data_o` does not change while the handshake for that byte is in progress.
- R3: `dma_req_o` stays high until the state code is sampled as binary 10. It is low from the following cycle on.
- R4: After the request is released, no new byte is accepted (`byte_ready_o` low) until the state code is sampled as any value other than binary 10.
- R5: `data_oe_o` is high only while the state code equals binary 10 and a byte handshake is in progress. It follows the state code in the same cycle, and it is low at all other times, including after an abort.
- R6: `byte_idx_o` is 0 at the start of a transfer and equals the number of bytes completed so far. It returns to 0 when the transfer finishes or aborts.
- R7: `done_o` is high for exactly one cycle, in the cycle after the edge at which the last byte's exit from the DMA state is sampled.
- R8: If the request waits TIMEOUT_CYCLES cycles without the DMA code appearing, or the DMA code persists for TIMEOUT_CYCLES cycles after the release, then `err_o` goes high, the request drops, the loader goes idle, and `done_o` is not raised. `err_o` clears on the next start.
- R9: `start_i` is ignored while a transfer is in progress. The transfer completes after its original length.
- R10: A start with length 0 gives a `done_o` pulse in the next cycle, with no request and no byte accepted.
- R11: After reset, all outputs are low and `byte_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer of `len_i` bytes |
| len_i | input | LEN_W | Number of bytes, sampled at start |
| byte_i | input | DATA_W | Next byte from the host |
| byte_valid_i | input | 1 | `byte_i` is valid |
| byte_ready_o | output | 1 | Loader accepts a byte this cycle |
| state_code_i | input | 2 | Processor state code; binary 10 is the DMA state |
| data_o | output | DATA_W | Byte driven toward the processor data bus |
| data_oe_o | output | 1 | Tristate enable for `data_o` |
| dma_req_o | output | 1 | DMA-input request to the processor |
| byte_idx_o | output | LEN_W | Index of the byte in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout error |

## Verification
The request is due SETTLE_CYCLES edges after the accept edge. The bench counts falling edges from the cycle in which it drives valid and expects SETTLE_CYCLES+1. The bus enable is combinational on the state code, so it is checked 1 ns after the bench changes the code. The request release and the readiness for the next byte appear one edge after the state code is sampled. The completion pulse and the index clear appear one edge after the exit from the DMA state; each is sampled on the falling edge that follows. Timeouts are checked as exact edge counts: TIMEOUT_CYCLES edges of request, or TIMEOUT_CYCLES+1 falling edges until the error shows while the code stays at DMA.

// File: rtl/dil_pkg.sv
package dil_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETTLE,
    ST_REQ,
    ST_EXIT
  } ld_state_e;

  localparam logic [1:0] SC_DMA = 2'b10;
endpackage

// File: rtl/dil_timer.sv
module dil_timer #(
  parameter int unsigned SETTLE_CYC  = 10,
  parameter int unsigned TIMEOUT_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic long_i,
  output logic hit_o
);
  localparam int unsigned MAXC = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!hit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = long_i ? (cnt_q == CW'(TIMEOUT_CYC - 1)) : (cnt_q == CW'(SETTLE_CYC - 1));

  p_cnt_bounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAXC - 1))
    else $error("timer ran past its limit");
endmodule

// File: rtl/dil_idx.sv
module dil_idx #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  input  logic             abort_i,
  output logic [LEN_W-1:0] idx_o,
  output logic             last_o
);
  logic [LEN_W-1:0] len_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      len_q <= len_i;
      idx_q <= '0;
    end else if (abort_i) begin
      idx_q <= '0;
    end else if (step_i) begin
      idx_q <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  assign last_o = (idx_q == len_q - 1'b1);
  assign idx_o  = idx_q;

  p_idx_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == '0) || (idx_q < len_q))
    else $error("byte index beyond length");
endmodule

// File: rtl/dil_bus.sv
module dil_bus #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              phase_i,
  input  logic [1:0]        state_code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  import dil_pkg::*;

  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (cap_i) data_q <= byte_i;
  end

  assign data_o    = data_q;
  // drive the shared bus only while the processor is in its DMA state
  assign data_oe_o = phase_i && (state_code_i == SC_DMA);

  p_data_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> (phase_i -> $stable(data_q)))
    else $error("data changed during handshake");
endmodule

// File: rtl/dil_fsm.sv
module dil_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic len_zero_i,
  input  logic valid_i,
  input  logic in_dma_i,
  input  logic hit_i,
  input  logic last_i,
  output logic ready_o,
  output logic req_o,
  output logic phase_o,
  output logic cap_o,
  output logic load_o,
  output logic step_o,
  output logic abort_o,
  output logic tmr_clr_o,
  output logic tmr_long_o,
  output logic done_o,
  output logic err_o
);
  import dil_pkg::*;

  ld_state_e state_q, state_d;
  logic      done_q, done_d, err_q, err_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = err_q;
    abort_o = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        err_d = 1'b0;
        if (len_zero_i) done_d  = 1'b1;
        else            state_d = ST_FETCH;
      end
      ST_FETCH:  if (valid_i) state_d = ST_SETTLE;
      ST_SETTLE: if (hit_i)   state_d = ST_REQ;
      ST_REQ: begin
        if (in_dma_i) state_d = ST_EXIT;
        else if (hit_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
          abort_o = 1'b1;
        end
      end
      ST_EXIT: begin
        if (!in_dma_i) begin
          step_o = 1'b1;
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_FETCH;
          end
        end else if (hit_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
          abort_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign ready_o    = (state_q == ST_FETCH);
  assign req_o      = (state_q == ST_REQ);
  assign phase_o    = (state_q == ST_REQ) || (state_q == ST_EXIT);
  assign cap_o      = ready_o && valid_i;
  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign tmr_clr_o  = (state_d != state_q);
  assign tmr_long_o = (state_q != ST_SETTLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  p_req_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && in_dma_i) |=> !req_o)
    else $error("request held after DMA state seen");

  p_req_after_settle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(state_q == ST_SETTLE && hit_i))
    else $error("request raised without settle");

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !load_o)
    else $error("reload while busy");
endmodule

// File: rtl/dma_in_loader.sv
module dma_in_loader #(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned LEN_W          = 16,
  parameter int unsigned SETTLE_CYCLES  = 10,
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [1:0]        state_code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              dma_req_o,
  output logic [LEN_W-1:0]  byte_idx_o,
  output logic              done_o,
  output logic              err_o
);
  import dil_pkg::*;

  logic in_dma, hit, last, phase, cap, load, step, abort, tmr_clr, tmr_long;

  assign in_dma = (state_code_i == SC_DMA);

  dil_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_zero_i (len_i == '0),
    .valid_i    (byte_valid_i),
    .in_dma_i   (in_dma),
    .hit_i      (hit),
    .last_i     (last),
    .ready_o    (byte_ready_o),
    .req_o      (dma_req_o),
    .phase_o    (phase),
    .cap_o      (cap),
    .load_o     (load),
    .step_o     (step),
    .abort_o    (abort),
    .tmr_clr_o  (tmr_clr),
    .tmr_long_o (tmr_long),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  dil_timer #(
    .SETTLE_CYC  (SETTLE_CYCLES),
    .TIMEOUT_CYC (TIMEOUT_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .long_i (tmr_long),
    .hit_o  (hit)
  );

  dil_idx #(.LEN_W(LEN_W)) u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (len_i),
    .step_i  (step),
    .abort_i (abort),
    .idx_o   (byte_idx_o),
    .last_o  (last)
  );

  dil_bus #(.DATA_W(DATA_W)) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_i        (cap),
    .byte_i       (byte_i),
    .phase_i      (phase),
    .state_code_i (state_code_i),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o)
  );

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_idx_zero_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (byte_idx_o == '0))
    else $error("index not cleared at done");

  p_no_ready_while_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o || data_oe_o) |-> !byte_ready_o)
    else $error("byte accepted during handshake");

  p_err_no_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!done_o && !dma_req_o && !byte_ready_o))
    else $error("abort left activity");

  p_oe_no_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!done_o && !err_o))
    else $error("bus driven outside handshake");
endmodule

// File: tb/dma_in_loader_bench.sv
`timescale 1ns/1ps
module dma_in_loader_bench;
  localparam int SETTLE = 10;
  localparam int TMO    = 40;
  localparam int LW     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] len_in = '0;
  logic [7:0]    byte_in = '0;
  logic          valid = 1'b0;
  logic          ready;
  logic [1:0]    sc = 2'b00;
  logic [7:0]    dout;
  logic          oe, req, done, err;
  logic [LW-1:0] idx;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  dma_in_loader #(
    .DATA_W(8), .LEN_W(LW), .SETTLE_CYCLES(SETTLE), .TIMEOUT_CYCLES(TMO)
  ) u_dma_in_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len_in),
    .byte_i(byte_in), .byte_valid_i(valid), .byte_ready_o(ready),
    .state_code_i(sc), .data_o(dout), .data_oe_o(oe), .dma_req_o(req),
    .byte_idx_o(idx), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic kick(input int len);
    @(negedge clk); start = 1'b1; len_in = LW'(len);
    @(negedge clk); start = 1'b0; len_in = '0;
  endtask

  // feed one byte and wait for the request; returns falling edges counted
  task automatic feed(input logic [7:0] b, input bit poke, output int c);
    int w = 0;
    while (!ready && w < 50) begin @(negedge clk); w++; end
    byte_in = b; valid = 1'b1;
    c = 0;
    do begin
      @(negedge clk); valid = 1'b0; c++;
      if (poke && c == 3) begin start = 1'b1; len_in = LW'(7); end
      else if (poke && c == 4) begin start = 1'b0; len_in = '0; end
    end while (!req && c < 200);
  endtask

  task automatic run_xfer(input int len, input int base, input int lat, input int hold, input int poke);
    int c;
    logic [7:0] b;
    kick(len);
    for (int i = 0; i < len; i++) begin
      b = 8'(base + i);
      chk(ready == 1'b1, "R1 ready for byte", int'(ready), 1);
      chk(idx == LW'(i), "R6 byte index", int'(idx), i);
      feed(b, (poke != 0) && (i == 0), c);
      chk(c == SETTLE + 1, "R2 settle before request", c, SETTLE + 1);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(req == 1'b1, "R3 request held", int'(req), 1);
      end
      sc = 2'b10; #1;
      chk(oe == 1'b1, "R5 bus enabled in DMA", int'(oe), 1);
      chk(dout == b, "R1 byte on bus", int'(dout), int'(b));
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(req == 1'b0, "R3 request released", int'(req), 0);
        chk(ready == 1'b0, "R4 no byte until exit", int'(ready), 0);
      end
      sc = 2'b00; #1;
      chk(oe == 1'b0, "R5 bus off after DMA", int'(oe), 0);
      @(negedge clk);
      if (i == len - 1) begin
        chk(done == 1'b1, "R7 done after last exit", int'(done), 1);
        chk(idx == '0, "R6 index cleared", int'(idx), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
      end else begin
        chk(done == 1'b0, "R7 no early done", int'(done), 0);
      end
    end
  endtask

  // len, base, latency to DMA, DMA hold, start poke
  localparam int VEC [0:4][0:4] = '{
    '{1, 8'h3C, 0, 1, 0},
    '{3, 8'hA0, 2, 1, 0},
    '{4, 8'hFE, 5, 3, 0},
    '{2, 8'h11, 1, 2, 1},
    '{5, 8'h70, 0, 4, 0}
  };

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int c;
    #1;
    chk(!req && !oe && !ready && !done && !err, "R11 outputs low in reset", int'(req | oe | ready | done | err), 0);
    chk(idx == '0, "R11 index zero", int'(idx), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !ready && !done, "R11 idle after reset", int'(req | ready | done), 0);

    for (int v = 0; v < 5; v++)
      run_xfer(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

    // R10: zero length
    kick(0);
    chk(done == 1'b1, "R10 zero length done", int'(done), 1);
    chk(!req && !ready, "R10 no request", int'(req | ready), 0);
    @(negedge clk);

    // R8: DMA state never entered
    kick(2);
    feed(8'h55, 1'b0, c);
    c = 0;
    while (req && c < 200) begin @(negedge clk); c++; end
    chk(c == TMO, "R8 request timeout length", c, TMO);
    chk(err == 1'b1, "R8 error raised", int'(err), 1);
    chk(idx == '0 && !done && !ready, "R8 idle after abort", int'(idx) + int'(done) + int'(ready), 0);
    repeat (2) @(negedge clk);
    chk(err == 1'b1, "R8 error sticky", int'(err), 1);

    // R8: error clears on start, transfer works afterwards
    run_xfer(1, 8'h9D, 1, 1, 0);
    chk(err == 1'b0, "R8 error cleared by start", int'(err), 1'b0);

    // R8/R5: DMA state never left
    kick(1);
    feed(8'hC3, 1'b0, c);
    sc = 2'b10;
    c = 0;
    while (!err && c < 200) begin @(negedge clk); c++; end
    chk(c == TMO + 1, "R8 stuck DMA timeout", c, TMO + 1);
    #1;
    chk(oe == 1'b0, "R5 bus released after abort", int'(oe), 0);
    chk(done == 1'b0, "R8 no done on abort", int'(done), 0);
    sc = 2'b00;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule